// File: doc/BRIEF.md
# Cycle Timestamp History Recorder

This block keeps a real-time clock made of a seconds count and a microsecond count. The microsecond count is advanced by an external tick and returns to zero once per second. A load port overwrites the seconds count at any time. On every measurement strobe the recorder writes the current time into a circular history buffer.

The write pointer of the buffer moves in step with the sample buffers of the loss-measurement channels. Both are set to the all-ones address by a shared buffer-reset command, so the first strobe after that command writes entry 0 in every buffer. A freeze input, raised after a beam abort, blocks writes and holds the pointer. The pointer then names the newest entry, and the history can be read back through a registered read port.

Three sum-latch strobes each capture the current timestamp into a holding register and raise an interrupt toward the controller. The interrupt stays high until a clear pulse arrives. A source field records which strobes fired since the last clear.

Top module: `ts_hist_rec`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, the microsecond and seconds counts are 0, `wr_ptr_o` is all ones (0xFFFF for a 16-bit address), `irq_o` is 0 and `irq_src_o` is 0.
- R2: Each cycle with `us_tick_i` high adds one to the microsecond count. A tick when the count equals `US_MAX` (default 999999) returns it to 0 and adds one to the seconds count, with the result visible the next cycle.
- R3: `sec_load_i` puts `sec_val_i` into the seconds count on the next cycle. It overrides a rollover increment in the same cycle, and the microsecond count still wraps to 0.
- R4: A `meas_i` pulse while not frozen and without `buf_rst_i` adds one to `wr_ptr_o`. It stores the time as it stood before that clock edge into the entry at the new pointer value.
- R5: `buf_rst_i` sets `wr_ptr_o` to all ones on the next cycle. It wins over a `meas_i` in the same cycle, which then writes nothing, and it acts while frozen.
- R6: While `freeze_i` is high, `meas_i` has no effect: `wr_ptr_o` holds and stored entries keep their contents.
- R7: `rd_sec_o`/`rd_us_o` show the entry at the `rd_addr_i` value sampled at the previous clock edge.
- R8: A cycle with any bit of `latch_i` high copies the pre-edge time into `lat_sec_o`/`lat_us_o`, and `irq_o` is high from the next cycle.
- R9: Bit i of `irq_src_o` is set by `latch_i[i]` and stays set until a clear. Strobes since the last clear accumulate by OR, and `irq_o` remains high while any source bit is set.
- R10: `irq_clr_i` empties `irq_src_o` and drops `irq_o` on the next cycle. A latch strobe in the same cycle wins: the source field then holds exactly that cycle's `latch_i` bits and `irq_o` stays high.
- R11: The pointer advances from depth-1 to 0, so the buffer is circular with 2^`ADDR_W` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-microsecond tick |
| sec_load_i | input | 1 | Load seconds count |
| sec_val_i | input | 32 | Seconds value to load |
| meas_i | input | 1 | Measurement strobe, one buffer write |
| buf_rst_i | input | 1 | Buffer-reset command, pointer to all ones |
| freeze_i | input | 1 | Abort freeze, blocks buffer writes |
| latch_i | input | 3 | Sum latch strobes |
| irq_clr_i | input | 1 | Interrupt clear write |
| rd_addr_i | input | ADDR_W | History read address |
| rd_sec_o | output | 32 | Read entry, seconds |
| rd_us_o | output | 24 | Read entry, microseconds |
| wr_ptr_o | output | ADDR_W | Address of newest entry |
| now_sec_o | output | 32 | Current seconds count |
| now_us_o | output | 24 | Current microsecond count |
| lat_sec_o | output | 32 | Latched seconds |
| lat_us_o | output | 24 | Latched microseconds |
| irq_o | output | 1 | Data-ready interrupt |
| irq_src_o | output | 3 | Strobes seen since last clear |

## Verification
Two pairs of functions can fall in the same cycle. The first is a seconds load together with a microsecond rollover. The bench watches the microsecond count and raises the tick and the load on exactly the cycle the count sits at its maximum, then expects the loaded value and not the incremented one. The second is a latch strobe together with an interrupt clear. The bench pulses both at once and expects the source field to hold only that cycle's strobe bits with the interrupt still high. A freeze and a buffer reset that coincide with a measurement strobe are provoked the same way, and the pointer and read-back entries are judged against the reference model.

// File: rtl/ts_hist_pkg.sv
package ts_hist_pkg;
  localparam int SEC_W   = 32;
  localparam int US_W    = 24;
  localparam int STAMP_W = SEC_W + US_W;
  localparam int N_LATCH = 3;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [US_W-1:0]  us;
  } stamp_t;
endpackage

// File: rtl/ts_rtc.sv
module ts_rtc
  import ts_hist_pkg::*;
#(
  parameter int US_MAX = 999999
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_val_i,
  output stamp_t           now_o
);
  logic [SEC_W-1:0] sec_q;
  logic [US_W-1:0]  us_q;
  logic             wrap;

  assign wrap = tick_i && (us_q == US_W'(US_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q  <= '0;
      sec_q <= '0;
    end else begin
      if (tick_i) us_q <= wrap ? '0 : us_q + 1'b1;
      // load overrides rollover increment
      if (load_i)    sec_q <= load_val_i;
      else if (wrap) sec_q <= sec_q + 1'b1;
    end
  end

  assign now_o = '{sec: sec_q, us: us_q};
endmodule

// File: rtl/ts_ring.sv
module ts_ring
  import ts_hist_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              meas_i,
  input  logic              buf_rst_i,
  input  logic              freeze_i,
  input  stamp_t            wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output stamp_t            rd_data_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int DEPTH = 1 << ADDR_W;

  stamp_t            mem [DEPTH];
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_inc;
  logic              we;

  assign ptr_inc = ptr_q + 1'b1;
  assign we      = meas_i && !freeze_i && !buf_rst_i;

  // pointer pre-increments so it always names the newest entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '1;
    else if (buf_rst_i) ptr_q <= '1;
    else if (we)        ptr_q <= ptr_inc;
  end

  always_ff @(posedge clk_i) begin
    if (we) mem[ptr_inc] <= wdata_i;
    rd_data_o <= mem[rd_addr_i];
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ts_latch_irq.sv
module ts_latch_irq
  import ts_hist_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LATCH-1:0] latch_i,
  input  logic               clr_i,
  input  stamp_t             now_i,
  output stamp_t             lat_o,
  output logic               irq_o,
  output logic [N_LATCH-1:0] src_o
);
  logic [N_LATCH-1:0] src_q;
  logic [N_LATCH-1:0] src_nxt;
  stamp_t             lat_q;

  // new strobes win over a same-cycle clear
  assign src_nxt = (clr_i ? '0 : src_q) | latch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      lat_q <= '0;
    end else begin
      src_q <= src_nxt;
      if (|latch_i) lat_q <= now_i;
    end
  end

  assign src_o = src_q;
  assign irq_o = |src_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/ts_hist_rec.sv
module ts_hist_rec
  import ts_hist_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int US_MAX = 999999
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               us_tick_i,
  input  logic               sec_load_i,
  input  logic [SEC_W-1:0]   sec_val_i,
  input  logic               meas_i,
  input  logic               buf_rst_i,
  input  logic               freeze_i,
  input  logic [N_LATCH-1:0] latch_i,
  input  logic               irq_clr_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [SEC_W-1:0]   rd_sec_o,
  output logic [US_W-1:0]    rd_us_o,
  output logic [ADDR_W-1:0]  wr_ptr_o,
  output logic [SEC_W-1:0]   now_sec_o,
  output logic [US_W-1:0]    now_us_o,
  output logic [SEC_W-1:0]   lat_sec_o,
  output logic [US_W-1:0]    lat_us_o,
  output logic               irq_o,
  output logic [N_LATCH-1:0] irq_src_o
);
  stamp_t now, rd_data, lat;

  ts_rtc #(.US_MAX(US_MAX)) u_rtc (
    .clk_i, .rst_ni,
    .tick_i     (us_tick_i),
    .load_i     (sec_load_i),
    .load_val_i (sec_val_i),
    .now_o      (now)
  );

  ts_ring #(.ADDR_W(ADDR_W)) u_ring (
    .clk_i, .rst_ni,
    .meas_i, .buf_rst_i, .freeze_i,
    .wdata_i   (now),
    .rd_addr_i,
    .rd_data_o (rd_data),
    .ptr_o     (wr_ptr_o)
  );

  ts_latch_irq u_latch (
    .clk_i, .rst_ni,
    .latch_i,
    .clr_i (irq_clr_i),
    .now_i (now),
    .lat_o (lat),
    .irq_o,
    .src_o (irq_src_o)
  );

  assign now_sec_o = now.sec;
  assign now_us_o  = now.us;
  assign rd_sec_o  = rd_data.sec;
  assign rd_us_o   = rd_data.us;
  assign lat_sec_o = lat.sec;
  assign lat_us_o  = lat.us;
endmodule

// File: rtl/ts_hist_rec_chk.sv
module ts_hist_rec_chk
  import ts_hist_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int US_MAX = 999999
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               us_tick_i,
  input logic               sec_load_i,
  input logic [SEC_W-1:0]   sec_val_i,
  input logic               meas_i,
  input logic               buf_rst_i,
  input logic               freeze_i,
  input logic [N_LATCH-1:0] latch_i,
  input logic               irq_clr_i,
  input logic [ADDR_W-1:0]  wr_ptr_o,
  input logic [US_W-1:0]    now_us_o,
  input logic [SEC_W-1:0]   now_sec_o,
  input logic               irq_o
);
  // R2
  us_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (us_tick_i && now_us_o == US_W'(US_MAX)) |=> now_us_o == '0);

  // R3
  sec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_load_i |=> now_sec_o == $past(sec_val_i));

  // R4
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_i && !freeze_i && !buf_rst_i) |=> wr_ptr_o == ADDR_W'($past(wr_ptr_o) + 1'b1));

  // R5
  buf_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rst_i |=> wr_ptr_o == '1);

  // R6
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !buf_rst_i) |=> $stable(wr_ptr_o));

  // R8
  latch_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|latch_i) |=> irq_o);

  // R10
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !(|latch_i)) |=> !irq_o);
endmodule

bind ts_hist_rec ts_hist_rec_chk #(.ADDR_W(ADDR_W), .US_MAX(US_MAX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .us_tick_i  (us_tick_i),
  .sec_load_i (sec_load_i),
  .sec_val_i  (sec_val_i),
  .meas_i     (meas_i),
  .buf_rst_i  (buf_rst_i),
  .freeze_i   (freeze_i),
  .latch_i    (latch_i),
  .irq_clr_i  (irq_clr_i),
  .wr_ptr_o   (wr_ptr_o),
  .now_us_o   (now_us_o),
  .now_sec_o  (now_sec_o),
  .irq_o      (irq_o)
);

// File: tb/tb_ts_hist_rec.sv
module tb_ts_hist_rec;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int UMAX  = 9;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              tick = 0, ld = 0, meas = 0, brst = 0, frz = 0, clr = 0;
  logic [31:0]       sval = 0;
  logic [2:0]        lat_in = 0;
  logic [AW-1:0]     raddr = 0;
  logic [31:0]       rd_sec, now_sec, l_sec;
  logic [23:0]       rd_us, now_us, l_us;
  logic [AW-1:0]     ptr;
  logic              irq;
  logic [2:0]        src;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ts_hist_rec #(.ADDR_W(AW), .US_MAX(UMAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .sec_load_i(ld),
    .sec_val_i(sval), .meas_i(meas), .buf_rst_i(brst), .freeze_i(frz),
    .latch_i(lat_in), .irq_clr_i(clr), .rd_addr_i(raddr),
    .rd_sec_o(rd_sec), .rd_us_o(rd_us), .wr_ptr_o(ptr),
    .now_sec_o(now_sec), .now_us_o(now_us), .lat_sec_o(l_sec),
    .lat_us_o(l_us), .irq_o(irq), .irq_src_o(src)
  );

  // reference model
  longint m_sec, m_us, m_ptr, m_lsec, m_lus, m_rsec, m_rus;
  int     m_src;
  bit     m_rd_ok;
  longint m_mem [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_us = 0; m_ptr = DEPTH - 1; m_src = 0;
      m_lsec = 0; m_lus = 0; m_rd_ok = 0;
    end else begin
      longint os, ou;
      os = m_sec; ou = m_us;
      m_rd_ok = m_mem.exists(int'(raddr));
      if (m_rd_ok) begin
        m_rsec = m_mem[int'(raddr)] >> 24;
        m_rus  = m_mem[int'(raddr)] & 64'hFFFFFF;
      end
      if (brst) m_ptr = DEPTH - 1;
      else if (meas && !frz) begin
        m_ptr = (m_ptr + 1) % DEPTH;
        m_mem[int'(m_ptr)] = (os << 24) | ou;
      end
      if (tick) begin
        if (ou == UMAX) begin
          m_us = 0;
          m_sec = (os + 1) % 64'h1_0000_0000;
        end else m_us = ou + 1;
      end
      if (ld) m_sec = sval;
      if (lat_in != 0) begin m_lsec = os; m_lus = ou; end
      m_src = (clr ? 0 : m_src) | int'(lat_in);
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 us", now_us, m_us);
      chk("R3 sec", now_sec, m_sec);
      chk("R4 ptr", ptr, m_ptr);
      chk("R8 lat_sec", l_sec, m_lsec);
      chk("R8 lat_us", l_us, m_lus);
      chk("R9 src", src, m_src);
      chk("R9 irq", irq, m_src != 0);
      if (m_rd_ok) begin
        chk("R7 rd_sec", rd_sec, m_rsec);
        chk("R7 rd_us", rd_us, m_rus);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    tick = 0; ld = 0; meas = 0; brst = 0; clr = 0; lat_in = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(2);
    // R1 during reset
    chk("R1 ptr", ptr, DEPTH - 1);
    chk("R1 us", now_us, 0);
    chk("R1 irq", irq, 0);
    @(posedge clk); #3 rst_n = 1;
    cyc(1);
    chk("R1 sec", now_sec, 0);
    chk("R1 src", src, 0);
    chk("R1 ptr_after", ptr, DEPTH - 1);

    // R2, R4, R11: ticking, periodic strobes, wrap of pointer
    for (int i = 0; i < 60; i++) begin
      tick = 1; meas = (i % 3 == 0);
      cyc(1);
    end
    idle(); cyc(1);
    chk("R11 ptr_wrapped", ptr, 19 % DEPTH);

    // R3: load colliding with rollover
    tick = 1;
    while (m_us != UMAX) cyc(1);
    ld = 1; sval = 32'hDEAD_0001;
    cyc(1); idle(); cyc(1);
    chk("R3 load_wins", now_sec, 32'hDEAD_0001);
    chk("R3 us_wrapped", now_us, 0);

    // R8, R9: latch strobes accumulate
    tick = 1; lat_in = 3'b001; cyc(1);
    lat_in = 3'b100; cyc(1);
    lat_in = 0; cyc(1);
    chk("R9 src_acc", src, 3'b101);
    chk("R8 irq", irq, 1);
    // R10: clear alone, then clear with latch
    clr = 1; cyc(1); clr = 0; cyc(1);
    chk("R10 cleared", irq, 0);
    lat_in = 3'b010; cyc(1); lat_in = 0; cyc(1);
    clr = 1; lat_in = 3'b100; cyc(1); idle(); cyc(1);
    chk("R10 latch_wins", src, 3'b100);
    chk("R10 irq_kept", irq, 1);
    clr = 1; cyc(1); idle();

    // R6: freeze blocks strobes
    tick = 1; frz = 1;
    for (int i = 0; i < 8; i++) begin meas = 1; cyc(1); end
    meas = 0;
    for (int a = 0; a < DEPTH; a++) begin raddr = AW'(a); cyc(1); end
    // R5: buffer reset wins over strobe, works while frozen
    brst = 1; meas = 1; cyc(1); idle(); cyc(1);
    chk("R5 ptr_ones_frozen", ptr, DEPTH - 1);
    frz = 0;
    meas = 1; cyc(1); idle(); cyc(1);
    chk("R5 first_write_at_0", ptr, 0);
    brst = 1; meas = 1; cyc(1); idle(); cyc(1);
    chk("R5 rst_beats_meas", ptr, DEPTH - 1);

    // mixed stimulus
    for (int i = 0; i < 4000; i++) begin
      tick   = ($urandom % 3) != 0;
      meas   = ($urandom % 4) == 0;
      brst   = ($urandom % 97) == 0;
      frz    = (i % 500) > 420;
      ld     = ($urandom % 53) == 0;
      sval   = $urandom;
      lat_in = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
      clr    = ($urandom % 7) == 0;
      raddr  = AW'($urandom);
      cyc(1);
    end
    idle(); frz = 0; cyc(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule